// File: doc/BRIEF.md
# Chip-Enable Toggle Watchdog

This block supervises a host processor that proves it is alive by pulsing the chip-enable input of a serial peripheral. A service is a bare toggle: chip enable goes high and then low again with no serial transfer taking place while it is high. When the watchdog is enabled and the host stops servicing it, the block drives a CPU reset pulse of fixed length. It also sets a sticky watchdog flag that remains set until the status register holding it is read.

Timing comes from whichever time base is active. With a 50 Hz or 60 Hz line base, each line cycle is one period (20 ms or 16.7 ms). With the crystal base, one period is `XTAL_DIV` crystal prescaler ticks (about 15.6 ms). The counter has two stages. The first period boundary after a service is only a warning, and the second one fires the reset. A host that services at least once per period is therefore never reset, and a host that stops is reset between one and two periods after its last service.

The controller is a four-state machine. `WD_OFF` is the disabled state. `WD_ARMED` means no boundary has passed since the last service. `WD_WARNED` means one boundary has passed. `WD_FIRE` means the reset pulse is being driven. The transitions are as follows:
- OFF→ARMED when enabled.
- ARMED/WARNED→OFF when disabled.
- ARMED→WARNED on a boundary.
- ARMED/WARNED→ARMED on a service.
- WARNED→FIRE on a boundary without service.
- FIRE→ARMED after `RST_CYCLES` cycles.

Top module: `ce_toggle_wdt`

## Requirements
- R1: After reset `cpu_rst` and `wd_flag` are 0 and the machine is in `WD_OFF`.
- R2: While `wd_en` is 0, period boundaries and chip-enable activity never raise `cpu_rst` or `wd_flag`.
- R3: With `tb_sel` 0 (50 Hz) or 1 (60 Hz), each `line_tick` is one period boundary and `xtal_tick` is ignored. With `tb_sel` 2 or 3 (crystal), every `XTAL_DIV`-th `xtal_tick` is a boundary and `line_tick` is ignored.
- R4: The first boundary after enabling, after a service or after a reset pulse produces no reset. The second consecutive boundary without service raises `cpu_rst` in the cycle after the clock edge that samples it.
- R5: `cpu_rst` stays high for exactly `RST_CYCLES` cycles, and the watchdog then re-arms in `WD_ARMED`.
- R6: A service is `ce` sampled high and then low, with `xfer_active` never sampled high from the rising cycle through the falling cycle. A service returns the machine to `WD_ARMED`.
- R7: A chip-enable high period during which `xfer_active` is seen high is not a service.
- R8: `wd_flag` is set when the reset pulse starts and stays set until `stat_rd` is pulsed. A set in the same cycle as `stat_rd` wins.
- R9: A service sampled in the same cycle as a boundary wins, so that boundary is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip-enable input used for service |
| xfer_active | input | 1 | High while a serial transfer is running |
| wd_en | input | 1 | Watchdog enable (control bit 7) |
| tb_sel | input | 2 | Time base: 0 = 50 Hz line, 1 = 60 Hz line, 2/3 = crystal |
| line_tick | input | 1 | One-cycle pulse per line cycle |
| xtal_tick | input | 1 | One-cycle pulse per crystal prescaler tick |
| stat_rd | input | 1 | One-cycle pulse when the status register is read |
| cpu_rst | output | 1 | CPU reset pulse, active high |
| wd_flag | output | 1 | Sticky watchdog flag (status bit 6) |

## Verification
Each input is driven for one cycle from a falling clock edge, and each result is sampled at a later falling edge. A boundary or service applied in one cycle changes the state at the next rising edge. That means `cpu_rst` and `wd_flag` are due at the falling edge right after the stimulus was released, and the bench samples them there. The pulse length is measured by counting the falling edges at which `cpu_rst` is high, so the expected count is exactly `RST_CYCLES`. The crystal-base checks count ticks from a known prescaler phase, so the no-reset check falls one tick before the second boundary and the reset check falls on the tick that completes it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_OFF    = 2'd0,
        WD_ARMED  = 2'd1,
        WD_WARNED = 2'd2,
        WD_FIRE   = 2'd3
    } wdt_state_e;

    typedef enum logic [1:0] {
        TB_LINE50 = 2'd0,
        TB_LINE60 = 2'd1,
        TB_XTAL   = 2'd2,
        TB_XTAL2  = 2'd3
    } wdt_base_e;
endpackage

// File: rtl/wdt_period_gen.sv
module wdt_period_gen #(
    parameter int XTAL_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] tb_sel,
    input  logic       line_tick,
    input  logic       xtal_tick,
    output logic       boundary
);
    import wdt_pkg::*;

    logic use_line;
    logic xtal_bnd;

    assign use_line = (tb_sel == TB_LINE50) || (tb_sel == TB_LINE60);

    generate
        if (XTAL_DIV <= 1) begin : g_nodiv
            assign xtal_bnd = xtal_tick;
        end else begin : g_div
            localparam int CW = $clog2(XTAL_DIV);
            localparam logic [CW-1:0] LAST = CW'(XTAL_DIV - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (xtal_tick && !use_line) begin
                    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                end
            end
            assign xtal_bnd = xtal_tick && (cnt == LAST);
        end
    endgenerate

    assign boundary = use_line ? line_tick : xtal_bnd;
endmodule

// File: rtl/wdt_svc_detect.sv
module wdt_svc_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic xfer_active,
    output logic svc
);
    logic ce_q;
    logic dirty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q  <= 1'b0;
            dirty <= 1'b0;
        end else begin
            ce_q <= ce;
            if (ce && !ce_q) begin
                dirty <= xfer_active;
            end else if (ce && xfer_active) begin
                dirty <= 1'b1;
            end
        end
    end

    assign svc = ce_q && !ce && !dirty && !xfer_active;
endmodule

// File: rtl/ce_toggle_wdt.sv
module ce_toggle_wdt #(
    parameter int XTAL_DIV   = 64,
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       xfer_active,
    input  logic       wd_en,
    input  logic [1:0] tb_sel,
    input  logic       line_tick,
    input  logic       xtal_tick,
    input  logic       stat_rd,
    output logic       cpu_rst,
    output logic       wd_flag
);
    import wdt_pkg::*;

    localparam int PW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [PW-1:0] PLAST = PW'(RST_CYCLES - 1);

    wdt_state_e    state, nxt;
    logic          boundary;
    logic          svc;
    logic [PW-1:0] pcnt;
    logic          flag_q;

    wdt_period_gen #(.XTAL_DIV(XTAL_DIV)) u_period (
        .clk(clk), .rst_n(rst_n), .tb_sel(tb_sel),
        .line_tick(line_tick), .xtal_tick(xtal_tick), .boundary(boundary)
    );

    wdt_svc_detect u_svc (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .xfer_active(xfer_active), .svc(svc)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            WD_OFF:    if (wd_en) nxt = WD_ARMED;
            WD_ARMED: begin
                if (!wd_en)        nxt = WD_OFF;
                else if (svc)      nxt = WD_ARMED;
                else if (boundary) nxt = WD_WARNED;
            end
            WD_WARNED: begin
                if (!wd_en)        nxt = WD_OFF;
                else if (svc)      nxt = WD_ARMED;
                else if (boundary) nxt = WD_FIRE;
            end
            WD_FIRE:   if (pcnt == PLAST) nxt = WD_ARMED;
            default:   nxt = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= WD_OFF;
            pcnt   <= '0;
            flag_q <= 1'b0;
        end else begin
            state <= nxt;
            pcnt  <= (state == WD_FIRE && nxt == WD_FIRE) ? pcnt + 1'b1 : '0;
            if (state != WD_FIRE && nxt == WD_FIRE) begin
                flag_q <= 1'b1;
            end else if (stat_rd) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cpu_rst = (state == WD_FIRE);
        wd_flag = flag_q;
    end
endmodule

// File: rtl/ce_toggle_wdt_chk.sv
module ce_toggle_wdt_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic wd_en,
    input logic stat_rd,
    input logic boundary,
    input logic svc,
    input logic cpu_rst,
    input logic wd_flag
);
    logic [31:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run <= '0;
        else        run <= cpu_rst ? run + 1 : '0;
    end

    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (!cpu_rst && !wd_flag) || !rst_n);

    a_r2_fire_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst) |-> $past(wd_en));

    a_r4_fire_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst) |-> $past(boundary) && !$past(svc));

    a_r5_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RST_CYCLES);

    a_r8_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst) |-> wd_flag);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && !stat_rd) |=> wd_flag);

    a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $rose(cpu_rst));
endmodule

bind ce_toggle_wdt ce_toggle_wdt_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .stat_rd(stat_rd),
    .boundary(boundary), .svc(svc), .cpu_rst(cpu_rst), .wd_flag(wd_flag)
);

// File: tb/sim_ce_toggle_wdt.sv
module sim_ce_toggle_wdt;
    localparam int XD = 8;
    localparam int RC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, xfer_active = 1'b0, wd_en = 1'b0;
    logic [1:0] tb_sel = 2'd0;
    logic line_tick = 1'b0, xtal_tick = 1'b0, stat_rd = 1'b0;
    logic cpu_rst, wd_flag;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ce_toggle_wdt #(.XTAL_DIV(XD), .RST_CYCLES(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .xfer_active(xfer_active),
        .wd_en(wd_en), .tb_sel(tb_sel), .line_tick(line_tick),
        .xtal_tick(xtal_tick), .stat_rd(stat_rd),
        .cpu_rst(cpu_rst), .wd_flag(wd_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic ltick();
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
    endtask

    task automatic xtick();
        @(negedge clk) xtal_tick = 1'b1;
        @(negedge clk) xtal_tick = 1'b0;
    endtask

    task automatic toggle(input logic with_xfer);
        @(negedge clk) ce = 1'b1;
        @(negedge clk) xfer_active = with_xfer;
        @(negedge clk) xfer_active = 1'b0;
        @(negedge clk) ce = 1'b0;
        @(negedge clk);
    endtask

    task automatic rearm();
        @(negedge clk) wd_en = 1'b0;
        @(negedge clk) wd_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_status();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cpu_rst", cpu_rst, 1'b0);
        chk("R1 wd_flag", wd_flag, 1'b0);
    endtask

    task automatic t_disabled();
        wd_en = 1'b0;
        for (int i = 0; i < 3; i++) ltick();
        toggle(1'b0);
        chk("R2 cpu_rst", cpu_rst, 1'b0);
        chk("R2 wd_flag", wd_flag, 1'b0);
    endtask

    task automatic t_fire_and_pulse();
        int n;
        rearm();
        ltick();
        chk("R4 first boundary", cpu_rst, 1'b0);
        ltick();
        chk("R4 second boundary", cpu_rst, 1'b1);
        chk("R8 flag set", wd_flag, 1'b1);
        n = 1;
        for (int i = 0; i < 3 * RC; i++) begin
            @(negedge clk);
            if (cpu_rst) n++;
            else break;
        end
        checks++;
        if (n != RC) begin
            fails++;
            $display("FAIL R5 pulse length: actual %0d expected %0d", n, RC);
        end
        ltick();
        chk("R5 rearm first boundary", cpu_rst, 1'b0);
        ltick();
        chk("R5 rearm second boundary", cpu_rst, 1'b1);
        repeat (RC + 1) @(negedge clk);
    endtask

    task automatic t_flag();
        repeat (4) @(negedge clk);
        chk("R8 flag held", wd_flag, 1'b1);
        rd_status();
        chk("R8 flag cleared", wd_flag, 1'b0);
    endtask

    task automatic t_service();
        rearm();
        ltick();
        toggle(1'b0);
        ltick();
        chk("R6 serviced", cpu_rst, 1'b0);
        ltick();
        chk("R6 unserviced after", cpu_rst, 1'b1);
        repeat (RC + 1) @(negedge clk);
        rd_status();
    endtask

    task automatic t_xfer();
        rearm();
        ltick();
        toggle(1'b1);
        ltick();
        chk("R7 toggle with transfer", cpu_rst, 1'b1);
        repeat (RC + 1) @(negedge clk);
        rd_status();
    endtask

    task automatic t_same_cycle();
        rearm();
        ltick();
        @(negedge clk) ce = 1'b1;
        @(negedge clk);
        @(negedge clk) begin ce = 1'b0; line_tick = 1'b1; end
        @(negedge clk) line_tick = 1'b0;
        chk("R9 service beats boundary", cpu_rst, 1'b0);
        ltick();
        chk("R9 next boundary warns", cpu_rst, 1'b0);
        ltick();
        chk("R9 then fires", cpu_rst, 1'b1);
        repeat (RC + 1) @(negedge clk);
        rd_status();
    endtask

    task automatic t_bases();
        tb_sel = 2'd1;
        rearm();
        for (int i = 0; i < 3 * XD; i++) xtick();
        chk("R3 60Hz ignores crystal", cpu_rst, 1'b0);
        ltick();
        ltick();
        chk("R3 60Hz line fires", cpu_rst, 1'b1);
        repeat (RC + 1) @(negedge clk);
        rd_status();
        @(negedge clk) tb_sel = 2'd2;
        rearm();
        for (int i = 0; i < 3; i++) ltick();
        chk("R3 crystal ignores line", cpu_rst, 1'b0);
        for (int i = 0; i < XD - 3 * XD + 3 * XD - 1; i++) xtick();
        for (int i = 0; i < XD; i++) xtick();
        chk("R3 crystal one tick short", cpu_rst, 1'b0);
        xtick();
        chk("R3 crystal second boundary", cpu_rst, 1'b1);
        repeat (RC + 1) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_fire_and_pulse();
        t_flag();
        t_service();
        t_xfer();
        t_same_cycle();
        t_bases();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule